// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Memory Write Loader

This block is the write side of a byte-wide parallel nonvolatile memory model. It watches an asynchronous-style strobe bus (active-low chip enable, output enable and write enable, plus an address and a data byte), sampled on the system clock. It collects up to one page of bytes into a buffer. Each byte position in the buffer has its own valid bit.

A load ends when no further byte arrives within a programmable window. The block then enters a timed programming period and reports it on `busy_o`. During that period it walks the page in ascending offset order and presents one commit per buffered byte on a write port. A behavioural storage array outside the block consumes these commits. Positions that were never loaded produce no commit.

Bytes whose page differs from the page of the load in progress are dropped and raise a sticky error flag. Strobes that arrive during programming are ignored.

Top module: `eepl_page_loader`

## Requirements
- R1: After reset, `busy_o`, `page_err_o` and `prog_we_o` are all 0.
- R2: A write is recognised only while chip enable and write enable are both low and output enable is high. A strobe with output enable low, or a pulse on one enable while the other is held high, loads nothing and starts no programming.
- R3: The address is taken when the write condition starts (the later of the two enable falls). The data is taken from the last sampled cycle before the condition ends (the earlier of the two enable rises). Address changes after the start, and data changes coinciding with the ending edge, are not captured.
- R4: Address bits [12:6] select the page and bits [5:0] select the offset within a 64-byte page. Commits carry `prog_addr_o = {page, offset}` and leave in strictly ascending offset order, all within one page.
- R5: Bytes may be loaded in any order. A byte loaded again within the same load replaces the earlier value.
- R6: `busy_o` rises exactly LOAD_CYCLES+2 clock cycles after the input cycle in which the last accepted strobe ends. An accepted byte arriving inside the window restarts it.
- R7: Only offsets loaded in the current load are committed. Each such offset is committed exactly once per programming period.
- R8: `busy_o` stays high for exactly PROG_CYCLES cycles. A new load is possible once it falls.
- R9: During a load, a byte whose page bits differ from the load's page is discarded, and `page_err_o` is set and stays set until reset.
- R10: Write strobes that begin while `busy_o` is high are ignored and do not start a later programming period.
- R11: `prog_we_o` is high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 13 | Byte address: page in [12:6], offset in [5:0] |
| data_i | input | 8 | Write data byte |
| busy_o | output | 1 | Programming period in progress |
| page_err_o | output | 1 | Sticky flag: a byte from a foreign page was dropped |
| prog_we_o | output | 1 | Commit strobe to the storage array |
| prog_addr_o | output | 13 | Commit address |
| prog_data_o | output | 8 | Commit data |

## Verification
The loader is driven by write-enable-controlled and chip-enable-controlled strobes. Comparing the two shows that the start and end of the write condition are combined correctly. Data is flipped on the ending edge and the address is moved mid-strobe, so that a capture one cycle off is visible in the committed values. An out-of-order load with an overwritten offset, and a load of closely spaced bytes, separate correct merging and window restart from premature programming. Inhibited strobes, a foreign-page byte, and a strobe during programming each check that nothing reaches the commit port that should not.

// File: rtl/eepl_pkg.sv
package eepl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ld_state_e;
endpackage

// File: rtl/eepl_strobe.sv
module eepl_strobe #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output logic              end_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              ce_q, oe_q, we_q, act_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              act;

  // write condition: both enables low, output enable high
  assign act     = ~ce_q & ~we_q & oe_q;
  assign start_o = act & ~act_d;
  assign end_o   = ~act & act_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      act_d  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      ce_q   <= ce_ni;
      oe_q   <= oe_ni;
      we_q   <= we_ni;
      addr_q <= addr_i;
      data_q <= data_i;
      act_d  <= act;
      data_o <= data_q;  // last value seen while the condition held
      if (start_o) addr_o <= addr_q;
    end
  end
endmodule

// File: rtl/eepl_cnt.sv
module eepl_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign hit_o = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && !hit_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eepl_page_buf.sv
module eepl_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [DATA_W-1:0]     byte_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic sel;
    assign sel = wr_i && (wr_off_i == OFF_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q[g] <= '0;
        mask_q[g] <= 1'b0;
      end else begin
        if (sel) byte_q[g] <= wr_data_i;
        if (sel)        mask_q[g] <= 1'b1;
        else if (clr_i) mask_q[g] <= 1'b0;
      end
    end
  end

  assign rd_data_o  = byte_q[rd_off_i];
  assign rd_valid_o = mask_q[rd_off_i];

  // R7: a clear with no concurrent load empties the mask
  assert_mask_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_i) |=> (mask_q == '0));
endmodule

// File: rtl/eepl_page_loader.sv
module eepl_page_loader #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int LOAD_CYCLES = 37500,   // byte-load window
  parameter int PROG_CYCLES = 2500000  // programming period, must exceed PAGE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              page_err_o,
  output logic              prog_we_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o
);
  import eepl_pkg::*;

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  ld_state_e         state_q;
  logic [PG_W-1:0]   page_q;
  logic              err_q, armed_q;
  logic [OFF_W:0]    pos_q;
  logic              start_p, end_p;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic              load_hit, prog_hit;

  eepl_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .start_o(start_p), .end_o(end_p), .addr_o(lat_addr), .data_o(lat_data)
  );

  logic            busy, byte_acc, page_ok, buf_wr, go_prog, walk, buf_clr;
  logic [PG_W-1:0] wr_page;

  assign busy     = (state_q == ST_PROG);
  assign byte_acc = end_p & armed_q;
  assign wr_page  = lat_addr[ADDR_W-1:OFF_W];
  assign page_ok  = (state_q == ST_IDLE) || (wr_page == page_q);
  assign buf_wr   = byte_acc & ~busy & page_ok;
  assign go_prog  = (state_q == ST_LOAD) & load_hit & ~armed_q & ~byte_acc;
  assign walk     = busy & ~pos_q[OFF_W];
  assign buf_clr  = busy & prog_hit;

  eepl_cnt #(.LIMIT(LOAD_CYCLES)) u_load_win (
    .clk_i, .rst_ni,
    .clr_i((state_q != ST_LOAD) | buf_wr),
    .en_i (state_q == ST_LOAD),
    .hit_o(load_hit)
  );

  eepl_cnt #(.LIMIT(PROG_CYCLES)) u_prog_tmr (
    .clk_i, .rst_ni,
    .clr_i(~busy),
    .en_i (busy),
    .hit_o(prog_hit)
  );

  eepl_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_i     (buf_wr),
    .wr_off_i (lat_addr[OFF_W-1:0]),
    .wr_data_i(lat_data),
    .clr_i    (buf_clr),
    .rd_off_i (pos_q[OFF_W-1:0]),
    .rd_data_o(rd_data),
    .rd_valid_o(rd_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      page_q      <= '0;
      err_q       <= 1'b0;
      armed_q     <= 1'b0;
      pos_q       <= '0;
      prog_we_o   <= 1'b0;
      prog_addr_o <= '0;
      prog_data_o <= '0;
    end else begin
      // strobes that begin during programming never arm
      if (start_p && !busy) armed_q <= 1'b1;
      else if (end_p)       armed_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (buf_wr) begin
          state_q <= ST_LOAD;
          page_q  <= wr_page;
        end
        ST_LOAD: begin
          if (byte_acc && !page_ok) err_q <= 1'b1;
          if (go_prog) state_q <= ST_PROG;
        end
        ST_PROG: if (prog_hit) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase

      if (!busy)     pos_q <= '0;
      else if (walk) pos_q <= pos_q + 1'b1;

      prog_we_o   <= walk & rd_valid;
      prog_addr_o <= {page_q, pos_q[OFF_W-1:0]};
      prog_data_o <= rd_data;
    end
  end

  assign busy_o     = busy;
  assign page_err_o = err_q;

  assert_commit_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_we_o |-> busy_o);
  assert_busy_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(page_err_o));
  assert_commit_one_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_we_o && $past(prog_we_o)) |->
      (prog_addr_o[ADDR_W-1:OFF_W] == $past(prog_addr_o[ADDR_W-1:OFF_W])));
  assert_commit_ascending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_we_o && $past(prog_we_o)) |->
      (prog_addr_o[OFF_W-1:0] > $past(prog_addr_o[OFF_W-1:0])));
endmodule

// File: tb/eepl_page_loader_tb.sv
module eepl_page_loader_tb_top;
  localparam int L = 40;
  localparam int P = 100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [12:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        busy_o, page_err_o, prog_we_o;
  logic [12:0] prog_addr_o;
  logic [7:0]  prog_data_o;

  eepl_page_loader #(.LOAD_CYCLES(L), .PROG_CYCLES(P)) dut_i (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .busy_o, .page_err_o, .prog_we_o, .prog_addr_o, .prog_data_o
  );

  always #2 clk_i = ~clk_i;  // 250 MHz

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  int n_com = 0, n_bad = 0;
  logic [12:0] log_a [64];
  logic [7:0]  log_d [64];

  always @(negedge clk_i) begin
    n_cyc <= n_cyc + 1;
    if (rst_ni && prog_we_o) begin
      if (n_com < 64) begin
        log_a[n_com] = prog_addr_o;
        log_d[n_com] = prog_data_o;
      end
      n_com = n_com + 1;
      if (!busy_o) n_bad = n_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_we(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; data_i = d; ce_ni = 0;
    @(negedge clk_i); we_ni = 0;
    repeat (3) @(negedge clk_i);
    we_ni = 1; data_i = ~d;
    @(negedge clk_i); ce_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic wr_ce(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; data_i = d; we_ni = 0;
    @(negedge clk_i); ce_ni = 0;
    repeat (3) @(negedge clk_i);
    ce_ni = 1; data_i = ~d;
    @(negedge clk_i); we_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (!busy_o && t < 2000) begin @(negedge clk_i); t++; end
    while (busy_o && t < 2000) begin @(negedge clk_i); t++; end
    chk(t < 2000, tag, t, 0);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(page_err_o == 0, "R1 err", page_err_o, 0);
    chk(prog_we_o == 0, "R1 commit", prog_we_o, 0);
  endtask

  task automatic t_single;
    int n = 0;
    n_com = 0;
    wr_we(13'h1A05, 8'h3C);
    repeat (L - 1) @(negedge clk_i);
    chk(busy_o == 0, "R6 busy early", busy_o, 0);
    @(negedge clk_i);
    chk(busy_o == 1, "R6 busy on time", busy_o, 1);
    while (busy_o && n < 1000) begin n++; @(negedge clk_i); end
    chk(n == P, "R8 busy length", n, P);
    chk(n_com == 1, "R7 single count", n_com, 1);
    chk(log_a[0] == 13'h1A05, "R4 single addr", log_a[0], 13'h1A05);
    chk(log_d[0] == 8'h3C, "R3 data at first rise", log_d[0], 8'h3C);
  endtask

  task automatic t_page_order;
    n_com = 0;
    wr_ce(13'h1545, 8'h11);
    wr_ce(13'h1541, 8'h22);
    wr_we(13'h157F, 8'h33);
    wr_ce(13'h1545, 8'h44);
    wait_idle("R5 wait");
    chk(n_com == 3, "R7 page count", n_com, 3);
    chk(log_a[0] == 13'h1541 && log_d[0] == 8'h22, "R4 first", log_a[0], 13'h1541);
    chk(log_a[1] == 13'h1545 && log_d[1] == 8'h44, "R5 overwrite", log_d[1], 8'h44);
    chk(log_a[2] == 13'h157F && log_d[2] == 8'h33, "R4 last", log_a[2], 13'h157F);
  endtask

  task automatic t_inhibit;
    n_com = 0;
    @(negedge clk_i); addr_i = 13'h0011; data_i = 8'hEE; oe_ni = 0; ce_ni = 0;
    @(negedge clk_i); we_ni = 0;
    repeat (3) @(negedge clk_i); we_ni = 1;
    @(negedge clk_i); ce_ni = 1; oe_ni = 1;
    @(negedge clk_i); we_ni = 0;
    repeat (3) @(negedge clk_i); we_ni = 1;
    @(negedge clk_i); ce_ni = 0;
    repeat (3) @(negedge clk_i); ce_ni = 1;
    repeat (L + 10) @(negedge clk_i);
    chk(busy_o == 0, "R2 no programming", busy_o, 0);
    chk(n_com == 0, "R2 no commit", n_com, 0);
  endtask

  task automatic t_addr_move;
    n_com = 0;
    @(negedge clk_i); addr_i = 13'h0203; data_i = 8'h5A; ce_ni = 0;
    @(negedge clk_i); we_ni = 0;
    repeat (2) @(negedge clk_i); addr_i = 13'h0300;
    @(negedge clk_i); we_ni = 1;
    @(negedge clk_i); ce_ni = 1;
    wait_idle("R3 wait");
    chk(n_com == 1 && log_a[0] == 13'h0203, "R3 address at start", log_a[0], 13'h0203);
    chk(log_d[0] == 8'h5A, "R3 data", log_d[0], 8'h5A);
  endtask

  task automatic t_page_err;
    n_com = 0;
    chk(page_err_o == 0, "R9 err clear", page_err_o, 0);
    wr_we(13'h0840, 8'h77);
    wr_we(13'h0C41, 8'h88);
    repeat (2) @(negedge clk_i);
    chk(page_err_o == 1, "R9 err set", page_err_o, 1);
    wait_idle("R9 wait");
    chk(n_com == 1 && log_a[0] == 13'h0840 && log_d[0] == 8'h77, "R9 foreign dropped", n_com, 1);
    wr_we(13'h0001, 8'h01);
    wait_idle("R9 wait2");
    chk(page_err_o == 1, "R9 sticky", page_err_o, 1);
  endtask

  task automatic t_busy_ignore;
    int t = 0;
    n_com = 0;
    wr_we(13'h0100, 8'h11);
    while (!busy_o && t < 500) begin @(negedge clk_i); t++; end
    wr_we(13'h0101, 8'h99);
    wait_idle("R10 wait");
    repeat (L + 10) @(negedge clk_i);
    chk(busy_o == 0, "R10 no second period", busy_o, 0);
    chk(n_com == 1 && log_a[0] == 13'h0100, "R10 strobe ignored", n_com, 1);
  endtask

  task automatic t_window;
    n_com = 0;
    for (int i = 0; i < 3; i++) begin
      wr_we(13'h1F80 + 13'(i), 8'hA0 + 8'(i));
      chk(busy_o == 0, "R6 window restarted", busy_o, 0);
      repeat (25) @(negedge clk_i);
    end
    wait_idle("R6 wait");
    chk(n_com == 3, "R6 one period three bytes", n_com, 3);
    chk(log_a[2] == 13'h1F82 && log_d[2] == 8'hA2, "R6 last byte", log_d[2], 8'hA2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_single;
    t_page_order;
    t_inhibit;
    t_addr_move;
    t_busy_ignore;
    t_window;
    t_page_err;
    chk(n_bad == 0, "R11 commit outside busy", n_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(negedge clk_i) begin
    if (n_cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", n_cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule